// File: doc/BRIEF.md
# Serial Register-Access Port

This block lets an external controller configure a chip over a four-wire serial link. The controller owns chip select, serial clock and serial data in. The block returns serial data out together with a separate output-enable, so that the pad can float the line whenever the port is not answering a read. The port holds a bank of 8-bit configuration registers, and their contents are presented in parallel to the rest of the chip.

Chip select falling opens a frame. The frame starts with a 7-bit device address and a direction bit. A write frame then carries a pointer byte and any number of data bytes. A read frame carries no pointer. It streams data from the pointer left behind by an earlier frame, so a controller sets the pointer with a write frame cut short after the pointer byte and then opens a read frame. The pointer steps forward after every data byte in both directions.

All serial inputs are brought into the system clock through synchronizer chains, and edges are found there. The serial clock must therefore stay well below the system clock. The port ignores everything until it has seen chip select go from high to low after reset.

Top module: `spi_regport`

## Requirements
- R1: Serial data in is captured on a rising serial-clock edge. Serial data out changes only after a falling serial-clock edge, so it is steady at the following rising edge.
- R2: The first seven bits after chip select falls, MSB first, must equal the device address (default 7'b0010000). If they do not, the frame has no effect: no register changes, the pointer is kept and the output stays disabled.
- R3: The eighth bit selects the direction: 0 gives a write frame, 1 gives a read frame.
- R4: In a write frame, the byte after the direction bit sets the pointer to its low PTR_W bits. Each complete byte after that is written to the register the pointer selects.
- R5: The output-enable stays low for the whole of a write frame.
- R6: A write frame that ends right after the pointer byte changes no register. A later read frame streams from that pointer.
- R7: In a read frame, the falling edge that ends the direction bit raises the output-enable and drives the MSB of the register at the pointer. Further bits follow MSB first.
- R8: The pointer advances by one after every complete data byte, read or written, and wraps modulo 2**PTR_W.
- R9: Chip select high ends any frame at once. A partly shifted byte is discarded, the output-enable drops and the pointer keeps its value.
- R10: Pointer values at or above NUM_REGS read as 0x00, and writes to them are ignored.
- R11: The mode flag `spi_sel` is set by the first high-to-low chip-select transition after reset. While chip select is held low from reset onward, serial activity has no effect.
- R12: After reset all registers and the pointer are zero, and the output-enable and `spi_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| sdo_oe | output | 1 | High while sdo should be driven onto the pad |
| spi_sel | output | 1 | Serial mode latched after reset |
| cfg_regs | output | NUM_REGS*8 | Register contents, register n at bits [8n+7:8n] |

## Verification
The bench builds the port with NUM_REGS set to 12 while the pointer stays 4 bits wide. This leaves pointer values 12 to 15 empty, so that writes being ignored there and reads returning zero can be observed. A burst that crosses from pointer 15 back to 0 then checks the wrap and the empty range in one frame. The synchronizer depth is kept at two stages, and the serial clock runs at six system clocks per phase. This exercises the narrowest sampling margin that the default depth allows.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   // frame decoder states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PTR,
      ST_WR,
      ST_RD,
      ST_SKIP
   } frame_st_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("spi_regport_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int PTR_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [PTR_W-1:0]           waddr,
   input  logic [BYTE_W-1:0]          wdata,
   input  logic [PTR_W-1:0]           raddr,
   output logic [BYTE_W-1:0]          rdata,
   output logic [NUM_REGS*BYTE_W-1:0] cfg
);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (we && waddr == PTR_W'(g))       q <= wdata;
         end
         assign cfg[g*BYTE_W +: BYTE_W] = q;
      end
   endgenerate

   // addresses past the bank fall through to zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr == PTR_W'(i)) rdata = cfg[i*BYTE_W +: BYTE_W];
      end
   end

   assert_oob_write_ignored_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      (we && (32'(waddr) >= NUM_REGS)) |=> $stable(cfg));

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
   import spi_regport_pkg::*;
#(
   parameter int         PTR_W    = 4,
   parameter logic [6:0] DEV_ADDR = 7'b0010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_s,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] rdata,
   output logic [PTR_W-1:0]  ptr,
   output logic              we,
   output logic [PTR_W-1:0]  waddr,
   output logic [BYTE_W-1:0] wdata,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              spi_sel
);

   frame_st_t         state;
   logic              sclk_d, cs_d;
   logic [2:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg, out_sr, shift_nxt;
   logic              rise, fall, cs_fall, byte_end;

   assign rise      = sclk_s & ~sclk_d;
   assign fall      = ~sclk_s & sclk_d;
   assign cs_fall   = ~cs_s & cs_d;
   assign shift_nxt = {shreg[BYTE_W-2:0], sdi_s};
   assign byte_end  = (bit_cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cs_d    <= 1'b0;
         state   <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         out_sr  <= '0;
         ptr     <= '0;
         we      <= 1'b0;
         waddr   <= '0;
         wdata   <= '0;
         sdo     <= 1'b0;
         sdo_oe  <= 1'b0;
         spi_sel <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
         we     <= 1'b0;
         if (cs_fall) spi_sel <= 1'b1;
         if (cs_s) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sdo_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: if (cs_fall) begin
                  state   <= ST_HDR;
                  bit_cnt <= '0;
               end
               ST_HDR: if (rise) begin
                  shreg   <= shift_nxt;
                  bit_cnt <= bit_cnt + 3'd1;
                  if (byte_end) begin
                     if (shift_nxt[7:1] != DEV_ADDR) state <= ST_SKIP;
                     else if (shift_nxt[0])          state <= ST_RD;
                     else                            state <= ST_PTR;
                  end
               end
               ST_PTR: if (rise) begin
                  shreg   <= shift_nxt;
                  bit_cnt <= bit_cnt + 3'd1;
                  if (byte_end) begin
                     ptr   <= shift_nxt[PTR_W-1:0];
                     state <= ST_WR;
                  end
               end
               ST_WR: if (rise) begin
                  shreg   <= shift_nxt;
                  bit_cnt <= bit_cnt + 3'd1;
                  if (byte_end) begin
                     we    <= 1'b1;
                     waddr <= ptr;
                     wdata <= shift_nxt;
                     ptr   <= ptr + 1'b1;
                  end
               end
               ST_RD: if (fall) begin
                  sdo_oe  <= 1'b1;
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd0) begin
                     sdo    <= rdata[BYTE_W-1];
                     out_sr <= {rdata[BYTE_W-2:0], 1'b0};
                  end else begin
                     sdo    <= out_sr[BYTE_W-1];
                     out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
                  end
                  if (byte_end) ptr <= ptr + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assert_oe_only_in_read_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (state == ST_RD));

   assert_cs_high_floats_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo_oe);

   assert_ptr_kept_idle_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (cs_s && cs_d) |=> $stable(ptr));

   assert_idle_until_mode_R11: assert property (
      @(posedge clk) disable iff (!rst_n)
      !spi_sel |-> (state == ST_IDLE));

   assert_write_from_wr_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      we |-> ($past(state) == ST_WR));

endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b0010000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk,
   input  logic                       cs_n,
   input  logic                       sdi,
   output logic                       sdo,
   output logic                       sdo_oe,
   output logic                       spi_sel,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);

   localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
         $error("spi_regport: NUM_REGS must lie in 2..256");
      end
   endgenerate

   logic sclk_s, cs_s, sdi_s;
   logic we;
   logic [PTR_W-1:0]  ptr, waddr;
   logic [BYTE_W-1:0] wdata, rdata;

   spi_regport_sync #(.STAGES(SYNC_STAGES)) i_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   spi_regport_sync #(.STAGES(SYNC_STAGES)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   spi_regport_sync #(.STAGES(SYNC_STAGES)) i_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   spi_regport_ctrl #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
      .rdata(rdata), .ptr(ptr),
      .we(we), .waddr(waddr), .wdata(wdata),
      .sdo(sdo), .sdo_oe(sdo_oe), .spi_sel(spi_sel));

   spi_regport_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(ptr), .rdata(rdata), .cfg(cfg_regs));

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;

   localparam int NREG = 12;
   localparam int H    = 6;
   localparam logic [6:0] DEV = 7'b0010000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic sdi = 1'b0;
   logic sdo, sdo_oe, spi_sel;
   logic [NREG*8-1:0] cfg_regs;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   int mem[16];
   int mptr = 0;

   always #4 clk = ~clk;

   spi_regport #(.NUM_REGS(NREG), .SYNC_STAGES(2), .DEV_ADDR(DEV)) i_spi_regport (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .spi_sel(spi_sel), .cfg_regs(cfg_regs));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int mdl_rd(input int a);
      return (a < NREG) ? mem[a] : 0;
   endfunction

   task automatic cmp_bank(input string req);
      for (int i = 0; i < NREG; i++) chk(req, cfg_regs[i*8 +: 8], mem[i]);
   endtask

   // one serial bit: data set while sclk low, sdo sampled just before the rise
   task automatic bit_cyc(input logic b, output logic so, output logic oe);
      sdi = b;
      repeat (H) @(negedge clk);
      so = sdo;
      oe = sdo_oe;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output int oe_hi);
      logic so, oe;
      oe_hi = 0;
      for (int i = 7; i >= 0; i--) begin
         bit_cyc(tx[i], so, oe);
         rx[i] = so;
         if (oe) oe_hi++;
      end
   endtask

   task automatic cs_lo;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cs_hi;
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (3*H) @(negedge clk);
   endtask

   task automatic wr_frame(input logic [6:0] a, input logic [7:0] p, input logic [7:0] dq[$]);
      logic [7:0] rx;
      int oe_hi;
      cs_lo();
      xbyte({a, 1'b0}, rx, oe_hi);
      chk("R5 header oe", oe_hi, 0);
      xbyte(p, rx, oe_hi);
      chk("R5 pointer oe", oe_hi, 0);
      if (a == DEV) mptr = p & 15;
      foreach (dq[k]) begin
         xbyte(dq[k], rx, oe_hi);
         chk("R5 data oe", oe_hi, 0);
         if (a == DEV) begin
            if (mptr < NREG) mem[mptr] = dq[k];
            mptr = (mptr + 1) & 15;
         end
      end
      cs_hi();
   endtask

   task automatic rd_frame(input logic [6:0] a, input int n);
      logic [7:0] rx;
      int oe_hi;
      cs_lo();
      xbyte({a, 1'b1}, rx, oe_hi);
      chk("R3 oe low during header", oe_hi, 0);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, rx, oe_hi);
         if (a == DEV) begin
            chk("R7 oe high", oe_hi, 8);
            chk("R1 R8 read byte", rx, mdl_rd(mptr));
            mptr = (mptr + 1) & 15;
         end else begin
            chk("R2 foreign read oe", oe_hi, 0);
         end
      end
      cs_hi();
      chk("R9 oe after cs high", sdo_oe, 0);
   endtask

   initial begin
      int cnt = 0;
      while (!done && cnt < 150000) begin
         @(posedge clk);
         cnt++;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic so, oe;
      logic [7:0] rx;
      int oe_hi;
      logic [15:0] junk;
      for (int i = 0; i < 16; i++) mem[i] = 0;

      // chip select held low across reset release
      cs_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R12 oe in reset", sdo_oe, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R12 spi_sel after reset", spi_sel, 0);
      chk("R12 oe after reset", sdo_oe, 0);
      cmp_bank("R12 bank zero");

      junk = {DEV, 1'b0, 8'h02};
      for (int i = 15; i >= 0; i--) bit_cyc(junk[i], so, oe);
      for (int i = 7; i >= 0; i--) bit_cyc(1'b1, so, oe);
      repeat (H) @(negedge clk);
      chk("R11 no mode while cs held low", spi_sel, 0);
      cmp_bank("R11 held-low traffic ignored");
      cs_n = 1'b1;
      repeat (3*H) @(negedge clk);

      // burst write from pointer 3
      wr_frame(DEV, 8'h03, '{8'hA5, 8'h3C, 8'h7E});
      chk("R11 mode latched", spi_sel, 1);
      cmp_bank("R4 R8 burst write");

      // partial write sets pointer, then read streams
      wr_frame(DEV, 8'h03, '{});
      cmp_bank("R6 partial write no change");
      rd_frame(DEV, 3);
      rd_frame(DEV, 1);

      // foreign device address
      wr_frame(7'b0010001, 8'h00, '{8'hFF});
      cmp_bank("R2 foreign write");
      rd_frame(7'b1010000, 1);
      wr_frame(DEV, 8'h04, '{});
      rd_frame(DEV, 1);

      // abort inside a data byte
      wr_frame(DEV, 8'h05, '{});
      cs_lo();
      xbyte({DEV, 1'b0}, rx, oe_hi);
      xbyte(8'h01, rx, oe_hi);
      mptr = 1;
      for (int i = 0; i < 4; i++) bit_cyc(1'b1, so, oe);
      cs_hi();
      chk("R9 oe after abort", sdo_oe, 0);
      cmp_bank("R9 aborted byte dropped");
      rd_frame(DEV, 2);

      // wrap and empty addresses; pointer byte upper bits dropped
      wr_frame(DEV, 8'hFE, '{8'h11, 8'h22, 8'h42, 8'h99});
      cmp_bank("R10 R8 wrap write");
      wr_frame(DEV, 8'h0B, '{});
      rd_frame(DEV, 6);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule